// File: doc/BRIEF.md
# Serial memory slave protocol engine

This block is the bus-side controller for a small byte-wide memory that sits behind a two-wire serial bus. It oversamples the clock and data lines with the system clock and finds start and stop conditions. It decodes the slave header byte and takes in a word address. It then turns bus traffic into single-cycle write and read strobes on a synchronous access port. Acknowledges and read data go back to the bus through one open-drain pull-down output.

The header byte picks one of two spaces. One is the main array. The other holds two special registers: a control register at address 1FF hex and a fault register at 0FF hex. One bit of the header becomes the top bit of the 9-bit address. The engine supports byte writes with auto-increment and current-address reads. It also supports random reads, made of a dummy write, a repeated start and a read header. It supports sequential reads that wrap from the last location to 0. Finally, a set-address operation is a stop placed where the repeated start would go, and it only loads the address counter.

The access port expects read data to follow the address combinationally within the same cycle. The reset input is asynchronous and active low, and it must be released in step with the clock.

Top module: `sm_serial_slave`

## Requirements
- R1: The header byte is decoded as follows. Bits 7..5 must be 101. Bit 4 selects the space (0 for the array, 1 for the registers). Bits 3..2 must be 00. Bit 1 is address bit 8. Bit 0 selects the direction (1 for read, 0 for write). An accepted header is acknowledged by pulling SDA low through the ninth clock.
- R2: A header with a wrong type field, or with nonzero fixed bits, gets no acknowledge. The engine then leaves SDA released for all following bytes until the next start.
- R3: A write header and a word address byte set the 9-bit address {header bit 1, word byte}. Each complete data byte is then acknowledged and written once, to the current address in the selected space. The address then advances by one.
- R4: A stop that comes before a data byte and its acknowledge clock are complete leaves the memory unchanged.
- R5: A stop right after the word address acknowledge loads the address counter and transfers no data. The next current-address read returns that location.
- R6: A read header that is not preceded by an address phase returns the byte at the counter. The counter holds the last accessed address plus one.
- R7: A random read returns the addressed byte, MSB first. It consists of a write header, a word address, a repeated start and a read header.
- R8: A master acknowledge after a read byte makes the engine send the next byte. The address runs from 1FF hex to 000.
- R9: A master not-acknowledge ends the read. SDA stays released for any further clocks until the next start, and those clocks do not advance the counter.
- R10: The engine changes SDA only while SCL is low. A start seen in the middle of a byte restarts header reception.
- R11: With header bit 4 set, addresses 1FF hex and 0FF hex reach the control and fault registers through the same write and read flows. The array is left untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| acc_space | output | 1 | 0 array, 1 special registers |
| acc_addr | output | 9 | Access address (address counter) |
| acc_wr | output | 1 | Single-cycle write strobe |
| acc_wdata | output | 8 | Write data, valid with acc_wr |
| acc_rd | output | 1 | Single-cycle read strobe; acc_rdata sampled in the same cycle |
| acc_rdata | input | 8 | Read data for acc_addr/acc_space |

## Verification
The bench builds the engine with SYNC_STAGES set to 3 rather than the default 2. This adds one cycle of input latency. It shows that start and stop detection and the acknowledge timing depend only on the synchronized SCL edges, not on a fixed delay. The bus is run with a 20-cycle SCL half period. That leaves room for the pull-down to settle before each rising SCL edge. With the 9-bit address fixed, the top of the address space is within reach. The wrap from 1FF hex to 000 in a sequential read is covered, and so are both register addresses.

// File: rtl/sm_pkg.sv
package sm_pkg;

  localparam int SM_BYTE_W = 8;
  localparam int SM_ADDR_W = SM_BYTE_W + 1;
  localparam logic [2:0] SM_DEV_KIND = 3'b101;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR,
    ST_HDR_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK
  } sm_state_e;

  typedef struct packed {
    logic [2:0] kind;
    logic       space;
    logic [1:0] zero;
    logic       msb;
    logic       rd;
  } sm_hdr_t;

  function automatic logic sm_hdr_ok(sm_hdr_t h);
    return (h.kind == SM_DEV_KIND) && (h.zero == 2'b00);
  endfunction

endpackage

// File: rtl/sm_bus_sync.sv
module sm_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_q    = scl_pipe[STAGES-1];
  assign sda_q    = sda_pipe[STAGES-1];
  assign scl_rise = scl_q & ~scl_prev;
  assign scl_fall = ~scl_q & scl_prev;
  assign start_ev = scl_q & scl_prev & sda_prev & ~sda_q;
  assign stop_ev  = scl_q & scl_prev & ~sda_prev & sda_q;

endmodule

// File: rtl/sm_shift_reg.sv
module sm_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         bit_in,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load)       q_d = load_val;
    else if (shift) q_d = {q[W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

endmodule

// File: rtl/sm_addr_ctr.sv
module sm_addr_ctr #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (load)     cnt_d = load_val;
    else if (inc) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/sm_serial_slave.sv
module sm_serial_slave
  import sm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_pull,
  output logic                 acc_space,
  output logic [SM_ADDR_W-1:0] acc_addr,
  output logic                 acc_wr,
  output logic [SM_BYTE_W-1:0] acc_wdata,
  output logic                 acc_rd,
  input  logic [SM_BYTE_W-1:0] acc_rdata
);

  localparam int BYTE_W = SM_BYTE_W;
  localparam int ADDR_W = SM_ADDR_W;
  localparam int BITC_W = $clog2(BYTE_W + 1);
  localparam logic [BITC_W-1:0] BITS_FULL = BITC_W'(BYTE_W);
  localparam logic [BITC_W-1:0] BITS_LAST = BITC_W'(BYTE_W - 1);

  logic scl_q, sda_q, scl_rise, scl_fall, start_ev, stop_ev;

  sm_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_q    (scl_q),
    .sda_q    (sda_q),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  sm_state_e          state_q, state_d;
  logic [BITC_W-1:0]  bitc_q, bitc_d;
  logic               space_q, space_d;
  logic               msb_q, msb_d;
  logic               rd_q, rd_d;
  logic               mack_q, mack_d;
  logic               pull_q, pull_d;

  logic               sh_load, sh_shift, sh_bit;
  logic [BYTE_W-1:0]  sh_q;
  logic               ctr_load, ctr_inc;
  logic [ADDR_W-1:0]  ctr_q;
  logic               wr_c, rd_c;
  sm_hdr_t            hdr;

  assign hdr = sm_hdr_t'(sh_q);

  sm_shift_reg #(.W(BYTE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sh_load),
    .load_val (acc_rdata),
    .shift    (sh_shift),
    .bit_in   (sh_bit),
    .q        (sh_q)
  );

  sm_addr_ctr #(.W(ADDR_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctr_load),
    .load_val ({msb_q, sh_q}),
    .inc      (ctr_inc),
    .cnt      (ctr_q)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    bitc_d   = bitc_q;
    space_d  = space_q;
    msb_d    = msb_q;
    rd_d     = rd_q;
    mack_d   = mack_q;
    pull_d   = pull_q;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    sh_bit   = sda_q;
    ctr_load = 1'b0;
    ctr_inc  = 1'b0;
    wr_c     = 1'b0;
    rd_c     = 1'b0;
    if (stop_ev) begin
      state_d = ST_IDLE;
      bitc_d  = '0;
      pull_d  = 1'b0;
    end else if (start_ev) begin
      state_d = ST_HDR;
      bitc_d  = '0;
      pull_d  = 1'b0;
    end else begin
      case (state_q)
        ST_HDR, ST_WADR, ST_WDAT: begin
          if (scl_rise && bitc_q != BITS_FULL) begin
            sh_shift = 1'b1;
            bitc_d   = bitc_q + 1'b1;
          end else if (scl_fall && bitc_q == BITS_FULL) begin
            bitc_d = '0;
            case (state_q)
              ST_HDR: begin
                if (sm_hdr_ok(hdr)) begin
                  pull_d  = 1'b1;
                  state_d = ST_HDR_ACK;
                  space_d = hdr.space;
                  msb_d   = hdr.msb;
                  rd_d    = hdr.rd;
                end else begin
                  state_d = ST_IDLE;
                end
              end
              ST_WADR: begin
                pull_d  = 1'b1;
                state_d = ST_WADR_ACK;
              end
              default: begin
                pull_d  = 1'b1;
                state_d = ST_WDAT_ACK;
              end
            endcase
          end
        end
        ST_HDR_ACK: begin
          if (scl_fall) begin
            if (rd_q) begin
              rd_c    = 1'b1;
              sh_load = 1'b1;
              ctr_inc = 1'b1;
              pull_d  = ~acc_rdata[BYTE_W-1];
              bitc_d  = '0;
              state_d = ST_RDAT;
            end else begin
              pull_d  = 1'b0;
              state_d = ST_WADR;
            end
          end
        end
        ST_WADR_ACK: begin
          if (scl_fall) begin
            pull_d   = 1'b0;
            ctr_load = 1'b1;
            state_d  = ST_WDAT;
          end
        end
        ST_WDAT_ACK: begin
          if (scl_fall) begin
            pull_d  = 1'b0;
            wr_c    = 1'b1;
            ctr_inc = 1'b1;
            state_d = ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (bitc_q == BITS_LAST) begin
              pull_d  = 1'b0;
              bitc_d  = '0;
              state_d = ST_RACK;
            end else begin
              sh_shift = 1'b1;
              sh_bit   = 1'b1;
              bitc_d   = bitc_q + 1'b1;
              pull_d   = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_d = ~sda_q;
          if (scl_fall) begin
            if (mack_q) begin
              rd_c    = 1'b1;
              sh_load = 1'b1;
              ctr_inc = 1'b1;
              pull_d  = ~acc_rdata[BYTE_W-1];
              state_d = ST_RDAT;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bitc_q  <= '0;
      space_q <= 1'b0;
      msb_q   <= 1'b0;
      rd_q    <= 1'b0;
      mack_q  <= 1'b0;
      pull_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bitc_q  <= bitc_d;
      space_q <= space_d;
      msb_q   <= msb_d;
      rd_q    <= rd_d;
      mack_q  <= mack_d;
      pull_q  <= pull_d;
    end
  end

  assign sda_pull  = pull_q;
  assign acc_space = space_q;
  assign acc_addr  = ctr_q;
  assign acc_wr    = wr_c;
  assign acc_wdata = sh_q;
  assign acc_rd    = rd_c;

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !scl_q) else $error("pull changed with SCL high"); // R10

  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state_q == ST_HDR && bitc_q == '0)) else $error("start did not rearm"); // R10

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_pull) else $error("SDA driven while idle"); // R2

  AST_WR_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> (acc_addr == $past(acc_addr) + 1'b1)) else $error("write did not advance"); // R3

  AST_RD_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> (acc_addr == $past(acc_addr) + 1'b1)) else $error("read did not advance"); // R8

endmodule

// File: tb/sm_serial_slave_bench.sv
module sm_serial_slave_bench;

  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m, sda_m;
  logic       sda_line;
  logic       sda_pull, acc_space, acc_wr, acc_rd;
  logic [8:0] acc_addr;
  logic [7:0] acc_wdata, acc_rdata;

  logic [7:0] mem [512];
  logic [7:0] ctrl_reg, fault_reg;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  sm_serial_slave #(.SYNC_STAGES(3)) u_sm_serial_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .sda_pull  (sda_pull),
    .acc_space (acc_space),
    .acc_addr  (acc_addr),
    .acc_wr    (acc_wr),
    .acc_wdata (acc_wdata),
    .acc_rd    (acc_rd),
    .acc_rdata (acc_rdata)
  );

  function automatic logic [7:0] fill(int i);
    logic [15:0] t;
    t = 16'(i) * 16'd37 + 16'd11;
    return t[7:0];
  endfunction

  function automatic logic [7:0] hb(logic x, logic msb, logic rd);
    return {3'b101, x, 2'b00, msb, rd};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= fill(i);
      ctrl_reg  <= 8'h00;
      fault_reg <= 8'h81;
    end else if (acc_wr) begin
      if (!acc_space)             mem[acc_addr] <= acc_wdata;
      else if (acc_addr == 9'h1FF) ctrl_reg      <= acc_wdata;
      else if (acc_addr == 9'h0FF) fault_reg     <= acc_wdata;
    end
  end

  assign acc_rdata = acc_space ? ((acc_addr == 9'h1FF) ? ctrl_reg :
                                  (acc_addr == 9'h0FF) ? fault_reg : 8'h00)
                               : mem[acc_addr];

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(logic b);
    sda_m = b; wq();
    scl_m = 1'b1; wq();
    wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    b = sda_line; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(~mack);
  endtask

  task automatic random_read(logic x, logic [8:0] a, output logic [7:0] d, output logic ok);
    logic k1, k2, k3;
    bus_start();
    send_byte(hb(x, a[8], 1'b0), k1);
    send_byte(a[7:0], k2);
    bus_start();
    send_byte(hb(x, a[8], 1'b1), k3);
    recv_byte(d, 1'b0);
    bus_stop();
    ok = k1 & k2 & k3;
  endtask

  task automatic current_read(output logic [7:0] d, output logic ok);
    bus_start();
    send_byte(hb(1'b0, 1'b0, 1'b1), ok);
    recv_byte(d, 1'b0);
    bus_stop();
  endtask

  task automatic set_address(logic [8:0] a);
    logic k;
    bus_start();
    send_byte(hb(1'b0, a[8], 1'b0), k);
    check("R5 header ack", 9'(k), 9'd1);
    send_byte(a[7:0], k);
    bus_stop();
  endtask

  task automatic t_reset();
    check("R1 reset pull", 9'(sda_pull), 9'd0);
    check("R1 reset write strobe", 9'(acc_wr), 9'd0);
  endtask

  task automatic t_write();
    logic k;
    bus_start();
    send_byte(hb(1'b0, 1'b0, 1'b0), k);
    check("R1 write header ack", 9'(k), 9'd1);
    send_byte(8'h10, k);
    check("R3 address ack", 9'(k), 9'd1);
    send_byte(8'h5A, k);
    check("R3 data ack", 9'(k), 9'd1);
    send_byte(8'h5B, k);
    bus_stop();
    check("R3 mem[010]", 9'(mem[9'h010]), 9'h05A);
    check("R3 mem[011]", 9'(mem[9'h011]), 9'h05B);
  endtask

  task automatic t_bad_header();
    logic k;
    bus_start();
    send_byte(8'b1100_0000, k);
    check("R2 wrong type nack", 9'(k), 9'd0);
    send_byte(8'h55, k);
    check("R2 silent after reject", 9'(k), 9'd0);
    bus_stop();
    bus_start();
    send_byte(8'b1010_0100, k);
    check("R2 fixed bits nack", 9'(k), 9'd0);
    bus_stop();
  endtask

  task automatic t_partial();
    logic k, ok;
    logic [7:0] d;
    bus_start();
    send_byte(hb(1'b0, 1'b0, 1'b0), k);
    send_byte(8'h30, k);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    check("R4 array untouched", 9'(mem[9'h030]), 9'(fill(9'h030)));
    random_read(1'b0, 9'h030, d, ok);
    check("R4 readback", 9'(d), 9'(fill(9'h030)));
  endtask

  task automatic t_random_current();
    logic ok;
    logic [7:0] d;
    random_read(1'b0, 9'h123, d, ok);
    check("R7 acks", 9'(ok), 9'd1);
    check("R7 data", 9'(d), 9'(fill(9'h123)));
    current_read(d, ok);
    check("R6 ack", 9'(ok), 9'd1);
    check("R6 data n+1", 9'(d), 9'(fill(9'h124)));
  endtask

  task automatic t_set_address();
    logic ok;
    logic [7:0] d;
    set_address(9'h0A0);
    current_read(d, ok);
    check("R5 data after set", 9'(d), 9'(fill(9'h0A0)));
  endtask

  task automatic t_seq_wrap();
    logic k;
    logic [7:0] d0, d1, d2;
    set_address(9'h1FE);
    bus_start();
    send_byte(hb(1'b0, 1'b0, 1'b1), k);
    recv_byte(d0, 1'b1);
    recv_byte(d1, 1'b1);
    recv_byte(d2, 1'b0);
    bus_stop();
    check("R8 byte 1FE", 9'(d0), 9'(fill(9'h1FE)));
    check("R8 byte 1FF", 9'(d1), 9'(fill(9'h1FF)));
    check("R8 wrap to 000", 9'(d2), 9'(fill(0)));
  endtask

  task automatic t_nack();
    logic k, ok;
    logic [7:0] d;
    bus_start();
    send_byte(hb(1'b0, 1'b0, 1'b0), k);
    send_byte(8'h40, k);
    bus_start();
    send_byte(hb(1'b0, 1'b0, 1'b1), k);
    recv_byte(d, 1'b0);
    check("R9 data before nack", 9'(d), 9'(fill(9'h040)));
    recv_byte(d, 1'b0);
    check("R9 released after nack", 9'(d), 9'h0FF);
    bus_stop();
    current_read(d, ok);
    check("R9 counter not advanced", 9'(d), 9'(fill(9'h041)));
  endtask

  task automatic t_restart();
    logic k;
    logic [7:0] d;
    bus_start();
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    bus_start();
    send_byte(hb(1'b0, 1'b0, 1'b1), k);
    check("R10 header after restart ack", 9'(k), 9'd1);
    recv_byte(d, 1'b0);
    bus_stop();
    check("R10 data after restart", 9'(d), 9'(fill(9'h042)));
  endtask

  task automatic t_regs();
    logic k, ok;
    logic [7:0] d;
    bus_start();
    send_byte(hb(1'b1, 1'b1, 1'b0), k);
    check("R11 register header ack", 9'(k), 9'd1);
    send_byte(8'hFF, k);
    send_byte(8'hC3, k);
    bus_stop();
    check("R11 control written", 9'(ctrl_reg), 9'h0C3);
    check("R11 array 1FF untouched", 9'(mem[9'h1FF]), 9'(fill(9'h1FF)));
    random_read(1'b1, 9'h0FF, d, ok);
    check("R11 fault read", 9'(d), 9'h081);
    random_read(1'b1, 9'h1FF, d, ok);
    check("R11 control read", 9'(d), 9'h0C3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    scl_m = 1'b1;
    sda_m = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write();
    t_bad_header();
    t_partial();
    t_random_current();
    t_set_address();
    t_seq_wrap();
    t_nack();
    t_restart();
    t_regs();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule